// File: doc/BRIEF.md
# Memory Access Fault Detector

This block stands between a processor core's load/store port and the memory bus. Each request carries an address, an access size, a read/write flag and the core's current privilege mode. Before the request reaches the bus, the block checks two things. The address must be aligned to the access size. A user-mode access must not reach the upper, kernel-only part of the address space. A request that breaks either rule is held back, and the block reports an address-error fault.

A request that passes both checks goes out on the bus. The block then waits for a device to acknowledge it. If no acknowledge arrives within a parameterised number of cycles, the block reports a bus-error fault. Every fault is a single-cycle pulse. It carries a cause code that tells loads from stores, and the address of the access that faulted, so the exception logic can capture both in one cycle.

Only one bus access is outstanding at a time. While an access waits for its acknowledge, the block deasserts its ready output and ignores new requests.

Top module: `mafd_fault_unit`

## Requirements
- R1: After reset, `fault_valid` and `fwd_valid` are low and `req_ready` is high.
- R2: A halfword access (`req_size` = 1) whose address bit 0 is 1 raises an address error.
- R3: A word access (`req_size` = 2) whose address bits 1:0 are not both 0 raises an address error.
- R4: A byte access (`req_size` = 0) is never misaligned. The reserved size encoding 3 always raises an address error.
- R5: When `user_mode` is 1, an access at or above `KERNEL_BASE` (default 0x8000_0000) raises an address error. Kernel mode (`user_mode` = 0) may access any address. User mode may access addresses below `KERNEL_BASE`.
- R6: An address error is reported as follows:
  - `fault_valid` is high for one cycle, in the cycle after the accepting edge.
  - `fault_cause` is 4 for a load or 5 for a store.
  - `fault_addr` is the request address.
  - The request is never forwarded (`fwd_valid` stays low), so address error takes precedence over bus error.
  - `req_ready` stays high.
- R7: A request that passes all checks is handled as follows:
  - `fwd_valid` is high in the accepting cycle.
  - `req_ready` is low from the next cycle until the bus acknowledges.
  - An acknowledge returns `req_ready` high with no fault.
- R8: If `bus_ack` is not high at any of the `TIMEOUT` rising edges after the accepting edge, the block reports a bus error:
  - `fault_valid` pulses for one cycle after the `TIMEOUT`-th edge.
  - `fault_cause` is 6 for a load or 7 for a store.
  - `fault_addr` is the forwarded address.
  - `req_ready` is high again.
- R9: An acknowledge sampled at the `TIMEOUT`-th edge still counts as a response, and no fault is raised.
- R10: These inputs have no effect:
  - A request presented while `req_ready` is low is not forwarded, and it neither faults nor changes the captured address.
  - `bus_ack` while no access is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Core presents a request |
| req_ready | output | 1 | Block can accept a request this cycle |
| req_addr | input | ADDR_W | Request byte address |
| req_size | input | 2 | 0 byte, 1 halfword, 2 word, 3 reserved |
| req_write | input | 1 | 1 store, 0 load |
| user_mode | input | 1 | 1 when the core runs in user mode |
| bus_ack | input | 1 | A device acknowledged the outstanding access |
| fwd_valid | output | 1 | Request is forwarded to the bus this cycle |
| fault_valid | output | 1 | One-cycle fault report |
| fault_cause | output | CAUSE_W | Fault cause code |
| fault_addr | output | ADDR_W | Address of the faulting access |

## Verification
The bench builds the block with `TIMEOUT` = 5 and leaves the other parameters at their defaults. A short timeout lets the bench cover the whole wait window cheaply. It checks the no-fault state at edge 4, the fault at edge 5, and an acknowledge that lands on the last edge. The 32-bit address and the default kernel boundary put the user/kernel split at 0x7FFF_FFFF/0x8000_0000, so both sides of that boundary are tested with each privilege mode.

// File: rtl/mafd_pkg.sv
package mafd_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_RSVD = 2'd3
   } acc_size_e;

   localparam int unsigned CAUSE_W = 5;

   localparam logic [CAUSE_W-1:0] CAUSE_ADDR_LD = 5'd4;
   localparam logic [CAUSE_W-1:0] CAUSE_ADDR_ST = 5'd5;
   localparam logic [CAUSE_W-1:0] CAUSE_BUS_LD  = 5'd6;
   localparam logic [CAUSE_W-1:0] CAUSE_BUS_ST  = 5'd7;

endpackage

// File: rtl/mafd_align_chk.sv
module mafd_align_chk
   import mafd_pkg::*;
#(
   parameter int unsigned ADDR_W       = 32,
   parameter bit          STRICT_ALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic              misaligned
);

   if (ADDR_W < 2) begin : g_bad_width
      $error("mafd_align_chk: ADDR_W must be at least 2");
   end

   logic rsvd;
   assign rsvd = (acc_size_e'(size) == SZ_RSVD);

   if (STRICT_ALIGN) begin : g_strict
      always_comb begin
         unique case (acc_size_e'(size))
            SZ_BYTE: misaligned = 1'b0;
            SZ_HALF: misaligned = addr[0];
            SZ_WORD: misaligned = |addr[1:0];
            default: misaligned = 1'b1;
         endcase
      end
   end else begin : g_relaxed
      logic unused_addr;
      assign unused_addr = ^addr;
      assign misaligned  = rsvd;
   end

endmodule

// File: rtl/mafd_priv_chk.sv
module mafd_priv_chk #(
   parameter int unsigned       ADDR_W      = 32,
   parameter logic [ADDR_W-1:0] KERNEL_BASE = {1'b1, {(ADDR_W-1){1'b0}}}
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              user_mode,
   output logic              violation
);

   if (KERNEL_BASE == '0) begin : g_all_kernel
      logic unused_addr;
      assign unused_addr = ^addr;
      assign violation   = user_mode;
   end else begin : g_split
      assign violation = user_mode && (addr >= KERNEL_BASE);
   end

endmodule

// File: rtl/mafd_bus_timer.sv
module mafd_bus_timer #(
   parameter int unsigned TIMEOUT = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic ack,
   output logic busy,
   output logic expire
);

   localparam int unsigned CNT_W = (TIMEOUT < 2) ? 1 : $clog2(TIMEOUT);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT - 1);

   if (TIMEOUT < 1) begin : g_bad_timeout
      $error("mafd_bus_timer: TIMEOUT must be at least 1");
   end

   logic [CNT_W-1:0] cnt_q;
   logic             busy_q;

   assign busy   = busy_q;
   assign expire = busy_q && !ack && (cnt_q == LAST);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!busy_q) begin
         busy_q <= start;
         cnt_q  <= '0;
      end else if (ack || expire) begin
         busy_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // R8
   cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (cnt_q <= LAST));

   // R7
   ack_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && ack) |=> !busy_q);

   // R8
   expire_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> !busy_q);

endmodule

// File: rtl/mafd_fault_unit.sv
module mafd_fault_unit
   import mafd_pkg::*;
#(
   parameter int unsigned       ADDR_W       = 32,
   parameter int unsigned       TIMEOUT      = 16,
   parameter bit                STRICT_ALIGN = 1'b1,
   parameter logic [ADDR_W-1:0] KERNEL_BASE  = {1'b1, {(ADDR_W-1){1'b0}}}
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_valid,
   output logic               req_ready,
   input  logic [ADDR_W-1:0]  req_addr,
   input  logic [1:0]         req_size,
   input  logic               req_write,
   input  logic               user_mode,
   input  logic               bus_ack,
   output logic               fwd_valid,
   output logic               fault_valid,
   output logic [CAUSE_W-1:0] fault_cause,
   output logic [ADDR_W-1:0]  fault_addr
);

   logic misaligned, priv_viol, addr_err;
   logic fire, timer_busy, expire;
   logic [ADDR_W-1:0] held_addr_q;
   logic              held_write_q;
   logic              fault_q;
   logic [CAUSE_W-1:0] cause_q;
   logic [ADDR_W-1:0]  faddr_q;

   mafd_align_chk #(
      .ADDR_W       (ADDR_W),
      .STRICT_ALIGN (STRICT_ALIGN)
   ) align_i (
      .addr       (req_addr),
      .size       (req_size),
      .misaligned (misaligned)
   );

   mafd_priv_chk #(
      .ADDR_W      (ADDR_W),
      .KERNEL_BASE (KERNEL_BASE)
   ) priv_i (
      .addr      (req_addr),
      .user_mode (user_mode),
      .violation (priv_viol)
   );

   assign req_ready = !timer_busy;
   assign fire      = req_valid && req_ready;
   assign addr_err  = misaligned || priv_viol;
   assign fwd_valid = fire && !addr_err;

   mafd_bus_timer #(
      .TIMEOUT (TIMEOUT)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (fwd_valid),
      .ack    (bus_ack),
      .busy   (timer_busy),
      .expire (expire)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         held_addr_q  <= '0;
         held_write_q <= 1'b0;
      end else if (fwd_valid) begin
         held_addr_q  <= req_addr;
         held_write_q <= req_write;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fault_q <= 1'b0;
         cause_q <= '0;
         faddr_q <= '0;
      end else begin
         fault_q <= (fire && addr_err) || expire;
         if (fire && addr_err) begin
            cause_q <= req_write ? CAUSE_ADDR_ST : CAUSE_ADDR_LD;
            faddr_q <= req_addr;
         end else if (expire) begin
            cause_q <= held_write_q ? CAUSE_BUS_ST : CAUSE_BUS_LD;
            faddr_q <= held_addr_q;
         end
      end
   end

   assign fault_valid = fault_q;
   assign fault_cause = cause_q;
   assign fault_addr  = faddr_q;

   // R6
   addr_fault_report_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && addr_err) |=> (fault_valid &&
         (fault_cause == CAUSE_ADDR_LD || fault_cause == CAUSE_ADDR_ST)));

   // R7
   fwd_then_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fwd_valid |=> !req_ready);

   // R8
   bus_fault_after_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_valid && fault_cause[1]) |-> $past(timer_busy));

   // R10
   fault_onehot_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({fire && addr_err, expire}));

endmodule

// File: tb/mafd_fault_unit_tb_top.sv
module mafd_fault_unit_tb_top;

   localparam int unsigned AW  = 32;
   localparam int unsigned TMO = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic [AW-1:0] req_addr = '0;
   logic [1:0]    req_size = '0;
   logic          req_write = 1'b0;
   logic          user_mode = 1'b0;
   logic          bus_ack = 1'b0;
   logic          fwd_valid;
   logic          fault_valid;
   logic [4:0]    fault_cause;
   logic [AW-1:0] fault_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   mafd_fault_unit #(.ADDR_W(AW), .TIMEOUT(TMO)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_size(req_size), .req_write(req_write),
      .user_mode(user_mode), .bus_ack(bus_ack), .fwd_valid(fwd_valid),
      .fault_valid(fault_valid), .fault_cause(fault_cause), .fault_addr(fault_addr)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // Present a request at a falling edge and check fwd_valid before the
   // accepting edge. Return at the falling edge after that edge, with
   // req_valid dropped.
   task automatic issue(input logic [AW-1:0] a, input logic [1:0] sz,
                        input logic wr, input logic um, input logic exp_fwd,
                        input string tag);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; req_size = sz; req_write = wr; user_mode = um;
      #1;
      check({tag, " fwd_valid"}, fwd_valid, exp_fwd);
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic expect_addr_err(input logic [AW-1:0] a, input logic [1:0] sz,
                                  input logic wr, input logic um, input string tag);
      issue(a, sz, wr, um, 1'b0, tag);
      check({tag, " fault_valid"}, fault_valid, 1'b1);
      check({tag, " cause"}, fault_cause, wr ? 5'd5 : 5'd4);
      check({tag, " addr"}, fault_addr, a);
      check({tag, " ready"}, req_ready, 1'b1);
   endtask

   // Clean access acknowledged at the k-th edge after acceptance.
   task automatic expect_ok(input logic [AW-1:0] a, input logic [1:0] sz,
                            input logic wr, input logic um, input int k,
                            input string tag);
      issue(a, sz, wr, um, 1'b1, tag);
      check({tag, " no addr fault"}, fault_valid, 1'b0);
      check({tag, " busy"}, req_ready, 1'b0);
      for (int i = 1; i < k; i++) @(negedge clk);
      bus_ack = 1'b1;
      @(negedge clk);
      bus_ack = 1'b0;
      check({tag, " ready after ack"}, req_ready, 1'b1);
      check({tag, " no fault after ack"}, fault_valid, 1'b0);
   endtask

   task automatic t_reset;
      // R1
      check("R1 fault_valid", fault_valid, 1'b0);
      check("R1 req_ready", req_ready, 1'b1);
      check("R1 fwd_valid", fwd_valid, 1'b0);
   endtask

   task automatic t_half;
      expect_addr_err(32'h0000_1001, 2'd1, 1'b0, 1'b0, "R2 half odd load");
      expect_addr_err(32'h0000_2003, 2'd1, 1'b1, 1'b0, "R2 half odd store");
      expect_ok(32'h0000_1002, 2'd1, 1'b0, 1'b0, 1, "R2 half even");
   endtask

   task automatic t_word;
      expect_addr_err(32'h0000_0102, 2'd2, 1'b0, 1'b0, "R3 word 2");
      expect_addr_err(32'h0000_0101, 2'd2, 1'b1, 1'b0, "R3 word 1");
      expect_addr_err(32'h0000_0103, 2'd2, 1'b0, 1'b0, "R3 word 3");
      expect_ok(32'h0000_0104, 2'd2, 1'b1, 1'b0, 2, "R3 word aligned");
   endtask

   task automatic t_byte;
      expect_ok(32'h0000_0007, 2'd0, 1'b0, 1'b0, 1, "R4 byte odd");
      expect_addr_err(32'h0000_0100, 2'd3, 1'b1, 1'b0, "R4 rsvd size");
   endtask

   task automatic t_priv;
      expect_addr_err(32'h8000_0000, 2'd2, 1'b0, 1'b1, "R5 user kernel base");
      expect_addr_err(32'hFFFF_FFFC, 2'd2, 1'b1, 1'b1, "R5 user top");
      expect_ok(32'h7FFF_FFFC, 2'd2, 1'b0, 1'b1, 1, "R5 user below base");
      expect_ok(32'h8000_0000, 2'd2, 1'b1, 1'b0, 1, "R5 kernel mode high");
   endtask

   task automatic t_pulse;
      // R6 one-cycle pulse; misaligned and kernel together still one report
      expect_addr_err(32'h9000_0001, 2'd2, 1'b1, 1'b1, "R6 combined");
      @(negedge clk);
      check("R6 pulse one cycle", fault_valid, 1'b0);
      check("R6 not forwarded busy", req_ready, 1'b1);
   endtask

   task automatic t_timeout(input logic wr, input string tag);
      issue(32'h0000_4440, 2'd2, wr, 1'b0, 1'b1, tag);
      for (int i = 1; i < TMO; i++) @(negedge clk);
      check({tag, " R8 no fault before limit"}, fault_valid, 1'b0);
      check({tag, " R8 busy before limit"}, req_ready, 1'b0);
      @(negedge clk);
      check({tag, " R8 fault"}, fault_valid, 1'b1);
      check({tag, " R8 cause"}, fault_cause, wr ? 5'd7 : 5'd6);
      check({tag, " R8 addr"}, fault_addr, 32'h0000_4440);
      check({tag, " R8 ready"}, req_ready, 1'b1);
      @(negedge clk);
      check({tag, " R8 pulse"}, fault_valid, 1'b0);
   endtask

   task automatic t_last_edge_ack;
      // R9
      expect_ok(32'h0000_0200, 2'd2, 1'b0, 1'b0, TMO, "R9 ack at last edge");
      @(negedge clk);
      check("R9 still no fault", fault_valid, 1'b0);
   endtask

   task automatic t_ignore;
      // R10: request while busy, then timeout reports original address
      issue(32'h0000_0800, 2'd2, 1'b0, 1'b0, 1'b1, "R10 first");
      req_valid = 1'b1; req_addr = 32'h0000_0801; req_size = 2'd2; req_write = 1'b1;
      #1;
      check("R10 busy no fwd", fwd_valid, 1'b0);
      @(negedge clk);
      req_valid = 1'b0;
      check("R10 busy req no fault", fault_valid, 1'b0);
      for (int i = 2; i < TMO; i++) @(negedge clk);
      @(negedge clk);
      check("R10 fault cause kept", fault_cause, 5'd6);
      check("R10 fault addr kept", fault_addr, 32'h0000_0800);
      // R10: stray ack while idle
      bus_ack = 1'b1;
      @(negedge clk);
      @(negedge clk);
      bus_ack = 1'b0;
      check("R10 stray ack ready", req_ready, 1'b1);
      check("R10 stray ack no fault", fault_valid, 1'b0);
      expect_addr_err(32'h0000_0003, 2'd1, 1'b0, 1'b0, "R10 after stray");
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_half();
      t_word();
      t_byte();
      t_priv();
      t_pulse();
      t_timeout(1'b0, "R8 load");
      t_timeout(1'b1, "R8 store");
      t_last_edge_ack();
      t_ignore();
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

endmodule